// File: doc/BRIEF.md
# Pseudo-Random Link Self-Test Checker

This block sits at the receive end of a 24-bit parallel link and checks it during a built-in self-test. The far end sends a 15-bit-register pseudo-random sequence, 24 bits per word. While the test enable is high and the link reports lock, the checker seeds a local copy of that sequence from the first non-zero word it receives. From then on it compares every word against the expected continuation of the sequence.

Mismatches are reported on the same 24 data pins that carry traffic in normal operation. A mode input chooses between two reports. One is a per-bit error map, refreshed every cycle. The other is a running error total that stops at 255. A pass flag rises once a parameterised number of consecutive bits has been checked with no error. That number stands for the bit-error-rate target. The flag is only meaningful while the link is locked. When the test enable is low, the block forwards received data with one register of delay.

Top module: `prbs_link_checker`

## Requirements
- R1: With `test_en` low, `out_data` equals the `rx_data` of the previous cycle and `pass` is low.
- R2: With `test_en` and `lock` high, all-zero words are idle and are not checked. The first non-zero word seeds the local generator and reports no error. Each later word is compared with the next 24 sequence bits. The generator is s' = {s[13:0], s[14]^s[13]}, and each step's new bit fills word bits 0 upward.
- R3: In map mode (`count_mode` low), bit i of `out_data` is 1 exactly when bit i of the word checked in the previous cycle differed from the expected bit.
- R4: In count mode (`count_mode` high), `out_data[7:0]` holds the total of mismatched bits over all checked words, including the word from the previous cycle. The total stops at 255. `out_data[23:8]` is zero.
- R5: The error total clears while `test_en` is low. A new test therefore starts its count at 0.
- R6: `pass` rises in the cycle after the last word that completes `PASS_BITS` consecutive error-free bits, counting 24 bits per clean word. Any word with an error restarts the run and forces `pass` low in the next cycle.
- R7: A cycle with `lock` low forces `pass` low, clears the run and drops synchronisation. The checker then reseeds from the next non-zero locked word.
- R8: After reset, `out_data` and `pass` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Self-test enable |
| count_mode | input | 1 | 0: per-bit error map, 1: saturating error total |
| lock | input | 1 | Receive clock recovery is locked |
| rx_data | input | W | Received parallel word |
| out_data | output | W | Received data, error map or error total |
| pass | output | 1 | Error-free run target reached while locked |

## Verification
The hardest state to reach from the ports is a checker that has lost lock and has to re-acquire the sequence mid-stream. The generator at the far end must keep running while the receiver reseeds from a word that is not the first one. To reach it, the stimulus drives a long clean run that brings `pass` high, injects an error, drops `lock` for a single cycle, and then resumes the sequence. Pass must then be earned again from zero. Saturation of the total is reached by inverting entire words, so that each one adds 24 errors.

// File: rtl/prbs_link_checker.sv
module prbs_link_checker #(
  parameter int W         = 24,
  parameter int CNT_W     = 8,
  parameter int PASS_BITS = 1_000_000_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic         count_mode,
  input  logic         lock,
  input  logic [W-1:0] rx_data,
  output logic [W-1:0] out_data,
  output logic         pass
);
  localparam int SW    = 15;
  localparam int PC_W  = $clog2(W + 1);
  localparam int SUM_W = CNT_W + PC_W;
  localparam int RUN_W = $clog2(PASS_BITS + W + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(PASS_BITS);
  localparam logic [RUN_W-1:0] RUN_STEP = RUN_W'(W);
  localparam logic [SUM_W-1:0] CNT_MAX  = SUM_W'((1 << CNT_W) - 1);

  function automatic logic [SW+W-1:0] advance(input logic [SW-1:0] s);
    logic [SW-1:0] st;
    logic [W-1:0]  wd;
    st = s;
    for (int i = 0; i < W; i++) begin
      wd[i] = st[SW-1] ^ st[SW-2];
      st    = {st[SW-2:0], wd[i]};
    end
    return {st, wd};
  endfunction

  function automatic logic [SW-1:0] seed_of(input logic [W-1:0] wd);
    logic [SW-1:0] st;
    for (int j = 0; j < SW; j++) st[SW-1-j] = wd[W-SW+j];
    return st;
  endfunction

  logic [SW-1:0]    state, state_nx;
  logic [W-1:0]     expect_w, err;
  logic             synced;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [RUN_W-1:0] run, run_nx, run_sum;
  logic [PC_W-1:0]  nerr;
  logic [SUM_W-1:0] cnt_sum;

  assign {state_nx, expect_w} = advance(state);
  assign err = rx_data ^ expect_w;

  always_comb begin
    nerr = '0;
    for (int i = 0; i < W; i++) nerr = nerr + PC_W'(err[i]);
  end

  assign cnt_sum = SUM_W'(cnt) + SUM_W'(nerr);
  assign cnt_nx  = (cnt_sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : cnt_sum[CNT_W-1:0];
  assign run_sum = run + RUN_STEP;
  assign run_nx  = (|err) ? '0 : ((run_sum >= RUN_MAX) ? RUN_MAX : run_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      pass     <= 1'b0;
      state    <= '0;
      synced   <= 1'b0;
      cnt      <= '0;
      run      <= '0;
    end else if (!test_en) begin
      out_data <= rx_data;
      pass     <= 1'b0;
      synced   <= 1'b0;
      cnt      <= '0;
      run      <= '0;
    end else if (!lock) begin
      synced   <= 1'b0;
      run      <= '0;
      pass     <= 1'b0;
      out_data <= count_mode ? W'(cnt) : '0;
    end else if (!synced) begin
      if (|rx_data) begin
        state  <= seed_of(rx_data);
        synced <= 1'b1;
      end
      pass     <= 1'b0;
      out_data <= count_mode ? W'(cnt) : '0;
    end else begin
      state    <= state_nx;
      cnt      <= cnt_nx;
      run      <= run_nx;
      pass     <= (run_nx >= RUN_MAX);
      out_data <= count_mode ? W'(cnt_nx) : err;
    end
  end
endmodule

module prbs_link_checker_sva #(
  parameter int W     = 24,
  parameter int CNT_W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         test_en,
  input logic         count_mode,
  input logic         lock,
  input logic [W-1:0] rx_data,
  input logic [W-1:0] out_data,
  input logic         pass
);
  AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(test_en)) |-> (out_data == $past(rx_data) && !pass)); // R1
  AST_PASS_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> $past(lock && test_en)); // R7
  AST_COUNT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test_en && count_mode)) |-> (out_data[W-1:CNT_W] == '0)); // R4
  AST_ERROR_CLEARS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(test_en && !count_mode) && (out_data != '0)) |-> !pass); // R6
  AST_COUNT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(test_en && count_mode) && $past(test_en && count_mode, 2))
      |-> (out_data[CNT_W-1:0] >= $past(out_data[CNT_W-1:0]))); // R4
endmodule

bind prbs_link_checker prbs_link_checker_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .count_mode(count_mode), .lock(lock),
  .rx_data(rx_data), .out_data(out_data), .pass(pass)
);

// File: tb/tb_prbs_link_checker.sv
module tb_prbs_link_checker;
  localparam int W = 24;
  localparam int NB = 240;

  logic clk = 1'b0, rst_n = 1'b0, test_en = 1'b0, count_mode = 1'b0, lock = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic [W-1:0] out_data;
  logic pass;

  always #2 clk = ~clk;

  prbs_link_checker #(.W(W), .CNT_W(8), .PASS_BITS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .count_mode(count_mode), .lock(lock),
    .rx_data(rx_data), .out_data(out_data), .pass(pass));

  int checks = 0, failures = 0;
  logic [W:0] exp_q[$];
  string      tag_q[$];
  bit         drive_done = 1'b0;

  logic [14:0] tx_s = 15'h1ACE;
  logic [14:0] m_s = '0;
  bit          m_sync = 1'b0;
  int          m_cnt = 0, m_run = 0;

  function automatic logic [W-1:0] gen(inout logic [14:0] s);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) begin
      logic b;
      b = s[14] ^ s[13];
      w[i] = b;
      s = (s << 1) | 15'(b);
    end
    return w;
  endfunction

  task automatic check(input logic [W-1:0] ao, input logic ap, input logic [W:0] e, input string tag);
    checks++;
    if ({ap, ao} !== e) begin
      failures++;
      $display("FAIL %s: got out=%h pass=%b, expected out=%h pass=%b", tag, ao, ap, e[W-1:0], e[W]);
    end
  endtask

  task automatic step(input logic en, input logic md, input logic lk, input logic [W-1:0] d, input string tag);
    logic [W-1:0] eo, ew, er;
    logic ep;
    int n;
    @(negedge clk);
    test_en = en; count_mode = md; lock = lk; rx_data = d;
    ep = 1'b0;
    if (!en) begin
      eo = d; m_cnt = 0; m_sync = 0; m_run = 0;
    end else if (!lk) begin
      m_sync = 0; m_run = 0;
      eo = md ? W'(m_cnt) : '0;
    end else if (!m_sync) begin
      if (d != 0) begin
        for (int j = 0; j < 15; j++) m_s[14-j] = d[W-15+j];
        m_sync = 1;
      end
      eo = md ? W'(m_cnt) : '0;
    end else begin
      ew = gen(m_s);
      er = d ^ ew;
      n = $countones(er);
      m_cnt = (m_cnt + n > 255) ? 255 : m_cnt + n;
      m_run = (n != 0) ? 0 : ((m_run + W > NB) ? NB : m_run + W);
      ep = (m_run >= NB);
      eo = md ? W'(m_cnt) : er;
    end
    exp_q.push_back({ep, eo});
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic md, input logic lk, input logic [W-1:0] flip, input string tag);
    logic [W-1:0] w;
    w = gen(tx_s);
    step(1'b1, md, lk, w ^ flip, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(out_data, pass, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin : watchdog
    #200000;
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check(out_data, pass, '0, "R8 reset");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 24'hA5C30F, "R1 passthru");
    step(0, 1, 1, 24'h00FF11, "R1 passthru");
    step(0, 0, 1, 24'hFFFFFF, "R1 passthru");
    repeat (3) step(1, 0, 1, '0, "R2 idle zeros");
    send(0, 1, '0, "R2 seed");
    for (int k = 0; k < 12; k++) send(0, 1, '0, "R6 clean run/pass");
    send(0, 1, 24'h020020, "R3 map error");
    send(0, 1, 24'h800001, "R3 map error");
    repeat (3) send(0, 1, '0, "R2 continue");
    send(0, 0, '0, "R7 lock drop");
    send(0, 1, '0, "R7 reseed");
    for (int k = 0; k < 11; k++) send(0, 1, '0, "R7 pass again");
    send(1, 1, 24'h000107, "R4 count");
    send(1, 1, '0, "R4 count hold");
    for (int k = 0; k < 12; k++) send(1, 1, 24'hFFFFFF, "R4 saturate");
    send(1, 0, '0, "R7 count while unlocked");
    step(0, 1, 1, 24'h123456, "R5 disable");
    send(1, 1, '0, "R5 count restart");
    send(1, 1, 24'h000010, "R5 count restart");
    repeat (2) @(negedge clk);
    drive_done = 1'b1;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d pending, expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule